// File: doc/BRIEF.md
# Receive Alarm Overlay and Data Substitution

This block sits at the parallel receive output of a multi-channel serial link. Each channel reports five fault conditions: the level of a general-purpose input, which counts as a fault when low, a serializer loss of signal, a loss of channel synchronization, a loss of PLL lock and an invalid code word. A shared enable word chooses which of these conditions are merged onto the channel's active-high alarm output. A second, independent set of enables chooses which conditions cause received data to be replaced. The invalid code word can only raise the alarm and never replaces data. While any enabled replacement condition is active, an accepted beat is swapped for the K30.7 control character (0xFE with the control flag set) in every byte lane when the 8b/10b decoder is in use. When the decoder is bypassed, the beat is swapped for all zeros with the control flags clear.

Each channel's received data passes through one register stage with a valid/ready handshake on both sides. The register fills when the upstream side offers a beat and the stage is empty or its content is being taken in the same cycle. If the downstream side holds ready low, the registered beat stays exactly as it is. The alarm output is registered every cycle from the same sampled status. For a beat that flows without stalling, data, control flags and alarm therefore leave in the same receive clock cycle.

The block also drives a forwarded copy of the receive clock. This copy runs when an enable bit is set and is held low when the bit is clear. The enable word is loaded through a single write strobe.

Top module: `rxalm_top`

## Requirements
- R1: After reset, every alarm output is 0, every output valid is 0, and the forwarded clock runs. The enable word reads as 0x001, so all alarm and replacement enables are off.
- R2: Each channel's alarm output is registered. One cycle after the status is sampled, it equals the OR of the enabled conditions. Alarm enables sit at enable-word bits 1 to 5: bit 1 for the general-purpose input being low, bit 2 for loss of signal, bit 3 for loss of sync, bit 4 for loss of PLL lock and bit 5 for an invalid code word.
- R3: An accepted beat is replaced exactly when at least one enabled replacement condition is active in its accept cycle. Replacement enables sit at bits 6 to 9: bit 6 for the general-purpose input being low, bit 7 for loss of signal, bit 8 for loss of sync and bit 9 for loss of PLL lock. Otherwise data and control flags pass unchanged, and an invalid code word never causes replacement.
- R4: With the decoder enable input at 1, a replaced beat carries 0xFE in every byte lane with every control flag at 1. With the input at 0, a replaced beat carries all-zero data with all control flags at 0.
- R5: While output valid is 1 and output ready is 0, the output valid, data and control flags keep their values on the next cycle.
- R6: Input ready is 1 whenever the output register is empty or output ready is 1, and 0 otherwise.
- R7: A beat accepted at a clock edge appears on the outputs right after that edge. If the output is taken and no new beat is accepted, output valid drops to 0 at the same edge.
- R8: The forwarded clock follows the receive clock while enable-word bit 0 is 1 and is held at 0 while it is 0. A change takes effect from the first high phase after the edge that wrote it.
- R9: A write strobe loads the whole enable word at the next clock edge. That word applies to every channel, but each channel's outputs depend only on its own status and data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Enable-word write strobe |
| cfg_wdata | input | 10 | Enable word to load |
| dec_en | input | 1 | 1 when the 8b/10b decoder is in use |
| gpi_i | input | NUM_CH | General-purpose input level per channel (fault when low) |
| los_i | input | NUM_CH | Loss of signal per channel |
| nosync_i | input | NUM_CH | Loss of channel synchronization per channel |
| nolock_i | input | NUM_CH | Loss of PLL lock per channel |
| badcode_i | input | NUM_CH | Invalid code word per channel |
| s_valid | input | NUM_CH | Upstream beat offered, per channel |
| s_ready | output | NUM_CH | Stage can take a beat, per channel |
| s_data | input | NUM_CH*8*LANES | Received data, channel 0 in the low slice |
| s_k | input | NUM_CH*LANES | Received control flags, one per byte lane |
| m_valid | output | NUM_CH | Registered beat present, per channel |
| m_ready | input | NUM_CH | Downstream takes the beat, per channel |
| m_data | output | NUM_CH*8*LANES | Registered, possibly replaced data |
| m_k | output | NUM_CH*LANES | Registered, possibly replaced control flags |
| alarm_o | output | NUM_CH | Registered active-high alarm per channel |
| rxclk_o | output | 1 | Forwarded receive clock, gated by enable-word bit 0 |

## Verification
A wrong enable bit or a mis-wired cause shows up as a wrong alarm level one edge after the status is applied. It also shows up as the wrong replacement choice on the next accepted beat. Both appear within a cycle of the fault pattern that exposes them, so the bench sweeps every enable combination against every fault pattern and compares against its model on every clock. A corrupted output register appears as changed data during a stall or a lost beat in the very next cycle. A stuck clock gate shows in the first high phase after the write.

// File: rtl/rxalm_pkg.sv
package rxalm_pkg;

  localparam int unsigned CFG_W    = 10;
  localparam int unsigned N_ALARM  = 5;
  localparam int unsigned N_REPL   = 4;
  localparam logic [7:0]  K30_7    = 8'hFE;

  // Cause order inside both enable groups:
  // 0 gpi low, 1 loss of signal, 2 loss of sync, 3 loss of lock, 4 bad code
  typedef struct packed {
    logic [N_REPL-1:0]  repl;
    logic [N_ALARM-1:0] alarm;
    logic               clk_en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{repl: '0, alarm: '0, clk_en: 1'b1};

endpackage

// File: rtl/rxalm_cfg.sv
module rxalm_cfg
  import rxalm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q,
  output logic             rxclk_o
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else if (we) cfg_q <= cfg_t'(wdata);
  end

  // enable captured while the clock is low so the gated copy has clean edges
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= CFG_RST.clk_en;
    else        gate_q <= cfg_q.clk_en;
  end

  assign rxclk_o = clk & gate_q;

endmodule

// File: rtl/rxalm_fault_merge.sv
module rxalm_fault_merge
  import rxalm_pkg::*;
(
  input  cfg_t cfg,
  input  logic gpi,
  input  logic los,
  input  logic nosync,
  input  logic nolock,
  input  logic badcode,
  output logic alarm,
  output logic subst
);

  logic [N_ALARM-1:0] cause;

  always_comb begin
    cause = {badcode, nolock, nosync, los, ~gpi};
    alarm = |(cause & cfg.alarm);
    subst = |(cause[N_REPL-1:0] & cfg.repl);
  end

endmodule

// File: rtl/rxalm_lane_pipe.sv
module rxalm_lane_pipe
  import rxalm_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alarm,
  input  logic               subst,
  input  logic               dec_en,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [8*LANES-1:0] s_data,
  input  logic [LANES-1:0]   s_k,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [8*LANES-1:0] m_data,
  output logic [LANES-1:0]   m_k,
  output logic               alarm_q
);

  localparam int unsigned DW = 8 * LANES;

  logic [DW-1:0]    nxt_data;
  logic [LANES-1:0] nxt_k;
  logic             take;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (subst) begin
        nxt_data[8*l +: 8] = dec_en ? K30_7 : 8'h00;
        nxt_k[l]           = dec_en;
      end else begin
        nxt_data[8*l +: 8] = s_data[8*l +: 8];
        nxt_k[l]           = s_k[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_k     <= '0;
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= alarm;
      if (take) begin
        m_valid <= 1'b1;
        m_data  <= nxt_data;
        m_k     <= nxt_k;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rxalm_top.sv
module rxalm_top
  import rxalm_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [9:0]                cfg_wdata,
  input  logic                      dec_en,
  input  logic [NUM_CH-1:0]         gpi_i,
  input  logic [NUM_CH-1:0]         los_i,
  input  logic [NUM_CH-1:0]         nosync_i,
  input  logic [NUM_CH-1:0]         nolock_i,
  input  logic [NUM_CH-1:0]         badcode_i,
  input  logic [NUM_CH-1:0]         s_valid,
  output logic [NUM_CH-1:0]         s_ready,
  input  logic [NUM_CH*8*LANES-1:0] s_data,
  input  logic [NUM_CH*LANES-1:0]   s_k,
  output logic [NUM_CH-1:0]         m_valid,
  input  logic [NUM_CH-1:0]         m_ready,
  output logic [NUM_CH*8*LANES-1:0] m_data,
  output logic [NUM_CH*LANES-1:0]   m_k,
  output logic [NUM_CH-1:0]         alarm_o,
  output logic                      rxclk_o
);

  localparam int unsigned DW = 8 * LANES;

  cfg_t cfg_q;

  rxalm_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .cfg_q   (cfg_q),
    .rxclk_o (rxclk_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic alarm_c;
    logic subst_c;

    rxalm_fault_merge u_merge (
      .cfg     (cfg_q),
      .gpi     (gpi_i[c]),
      .los     (los_i[c]),
      .nosync  (nosync_i[c]),
      .nolock  (nolock_i[c]),
      .badcode (badcode_i[c]),
      .alarm   (alarm_c),
      .subst   (subst_c)
    );

    rxalm_lane_pipe #(.LANES(LANES)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .alarm   (alarm_c),
      .subst   (subst_c),
      .dec_en  (dec_en),
      .s_valid (s_valid[c]),
      .s_ready (s_ready[c]),
      .s_data  (s_data[c*DW +: DW]),
      .s_k     (s_k[c*LANES +: LANES]),
      .m_valid (m_valid[c]),
      .m_ready (m_ready[c]),
      .m_data  (m_data[c*DW +: DW]),
      .m_k     (m_k[c*LANES +: LANES]),
      .alarm_q (alarm_o[c])
    );
  end

endmodule

// File: rtl/rxalm_chk.sv
module rxalm_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned LANES  = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [4:0]                alarm_en,
  input logic [3:0]                repl_en,
  input logic [NUM_CH-1:0]         s_valid,
  input logic [NUM_CH-1:0]         s_ready,
  input logic [NUM_CH*8*LANES-1:0] s_data,
  input logic [NUM_CH*LANES-1:0]   s_k,
  input logic [NUM_CH-1:0]         m_valid,
  input logic [NUM_CH-1:0]         m_ready,
  input logic [NUM_CH*8*LANES-1:0] m_data,
  input logic [NUM_CH*LANES-1:0]   m_k,
  input logic [NUM_CH-1:0]         alarm_o
);

  localparam int unsigned DW = 8 * LANES;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r2_alarm_off: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_en == '0) |=> !alarm_o[c]);

    a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid[c] && s_ready[c] && repl_en == '0) |=>
        (m_data[c*DW +: DW] == $past(s_data[c*DW +: DW]) &&
         m_k[c*LANES +: LANES] == $past(s_k[c*LANES +: LANES])));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[c] && !m_ready[c]) |=>
        (m_valid[c] && $stable(m_data[c*DW +: DW]) && $stable(m_k[c*LANES +: LANES])));

    a_r6_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid[c] |-> s_ready[c]);

    a_r7_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid[c] && s_ready[c]) |=> m_valid[c]);
  end

endmodule

bind rxalm_top rxalm_chk #(.NUM_CH(NUM_CH), .LANES(LANES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .alarm_en (cfg_q.alarm),
  .repl_en  (cfg_q.repl),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_data   (s_data),
  .s_k      (s_k),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_data   (m_data),
  .m_k      (m_k),
  .alarm_o  (alarm_o)
);

// File: tb/rxalm_top_tb_top.sv
module rxalm_top_tb_top;

  localparam int NCH = 2;
  localparam int LN  = 2;
  localparam int DW  = 8 * LN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic dec_en = 1'b0;
  logic [NCH-1:0] gpi_i = '1, los_i = '0, nosync_i = '0, nolock_i = '0, badcode_i = '0;
  logic [NCH-1:0] s_valid = '0, s_ready, m_valid, m_ready = '0, alarm_o;
  logic [NCH*DW-1:0] s_data = '0, m_data;
  logic [NCH*LN-1:0] s_k = '0, m_k;
  logic rxclk_o;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [9:0]    cfg_m = 10'h001;
  logic          mv_m [NCH];
  logic [DW-1:0] md_m [NCH];
  logic [LN-1:0] mk_m [NCH];
  logic          al_m [NCH];
  string         dtag [NCH];

  always #5 clk = ~clk;

  rxalm_top #(.NUM_CH(NCH), .LANES(LN)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one clock: check combinational ready, predict, advance, compare
  task automatic tick();
    logic [9:0]    cfg_n;
    logic          exp_clk;
    logic          mv_n [NCH];
    logic [DW-1:0] md_n [NCH];
    logic [LN-1:0] mk_n [NCH];
    logic          al_n [NCH];
    string         tg_n [NCH];
    #1;
    cfg_n   = cfg_we ? cfg_wdata : cfg_m;
    exp_clk = cfg_m[0];
    for (int c = 0; c < NCH; c++) begin
      logic [4:0] cause;
      logic rdy, sub;
      cause = {badcode_i[c], nolock_i[c], nosync_i[c], los_i[c], ~gpi_i[c]};
      al_n[c] = |(cause & cfg_m[5:1]);
      sub     = |(cause[3:0] & cfg_m[9:6]);
      rdy     = !mv_m[c] || m_ready[c];
      chk(s_ready[c] == rdy, "R6", $sformatf("s_ready ch%0d", c), s_ready[c], rdy);
      mv_n[c] = mv_m[c]; md_n[c] = md_m[c]; mk_n[c] = mk_m[c]; tg_n[c] = "R5";
      if (s_valid[c] && rdy) begin
        mv_n[c] = 1'b1;
        if (sub) begin
          md_n[c] = dec_en ? {LN{8'hFE}} : '0;
          mk_n[c] = dec_en ? '1 : '0;
          tg_n[c] = "R4";
        end else begin
          md_n[c] = s_data[c*DW +: DW];
          mk_n[c] = s_k[c*LN +: LN];
          tg_n[c] = "R3";
        end
      end else if (m_ready[c]) begin
        mv_n[c] = 1'b0;
      end
    end
    @(posedge clk);
    #2;
    cfg_m = cfg_n;
    for (int c = 0; c < NCH; c++) begin
      mv_m[c] = mv_n[c]; md_m[c] = md_n[c]; mk_m[c] = mk_n[c];
      al_m[c] = al_n[c]; dtag[c] = tg_n[c];
      chk(alarm_o[c] == al_m[c], "R2", $sformatf("alarm ch%0d", c), alarm_o[c], al_m[c]);
      chk(m_valid[c] == mv_m[c], "R7", $sformatf("m_valid ch%0d", c), m_valid[c], mv_m[c]);
      if (mv_m[c]) begin
        chk(m_data[c*DW +: DW] == md_m[c], dtag[c], $sformatf("m_data ch%0d", c),
            m_data[c*DW +: DW], md_m[c]);
        chk(m_k[c*LN +: LN] == mk_m[c], dtag[c], $sformatf("m_k ch%0d", c),
            m_k[c*LN +: LN], mk_m[c]);
      end
    end
    chk(rxclk_o == exp_clk, "R8", "rxclk high phase", rxclk_o, exp_clk);
  endtask

  task automatic write_cfg(input logic [9:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mv_m[c] = 0; md_m[c] = '0; mk_m[c] = '0; al_m[c] = 0; dtag[c] = "R3";
    end
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state at the ports
    for (int c = 0; c < NCH; c++) begin
      chk(alarm_o[c] == 1'b0, "R1", "alarm in reset", alarm_o[c], 0);
      chk(m_valid[c] == 1'b0, "R1", "m_valid in reset", m_valid[c], 0);
    end
    chk(rxclk_o == 1'b1, "R1", "rxclk runs in reset", rxclk_o, 1);
    rst_n = 1'b1;

    // R1: all faults active with the reset enable word: no alarm, no replacement
    gpi_i = '0; los_i = '1; nosync_i = '1; nolock_i = '1; badcode_i = '1;
    dec_en = 1'b1; s_valid = '1; m_ready = '1;
    s_data = {16'h1234, 16'hA55A}; s_k = 4'b0110;
    tick(); tick();
    chk(alarm_o == '0, "R1", "alarm after reset with faults", alarm_o, 0);
    chk(m_data[DW-1:0] == 16'hA55A, "R1", "no replacement after reset", m_data[DW-1:0], 16'hA55A);

    // R9: one enable word, per-channel status stays separate
    gpi_i = 2'b10; los_i = '0; nosync_i = '0; nolock_i = '0; badcode_i = '0;
    write_cfg(10'h003);
    tick();
    chk(alarm_o[0] == 1'b1, "R9", "ch0 alarm from own gpi", alarm_o[0], 1);
    chk(alarm_o[1] == 1'b0, "R9", "ch1 unaffected by ch0 gpi", alarm_o[1], 0);

    // R8: clock off then on
    write_cfg(10'h000);
    tick();
    #3;
    chk(rxclk_o == 1'b0, "R8", "rxclk low phase while off", rxclk_o, 0);
    write_cfg(10'h001);
    tick();

    // R5: stall with changing input must hold the output beat
    m_ready = '0; s_valid = '1; s_data = 32'hDEADBEEF;
    tick();
    s_data = 32'h01020304;
    tick(); tick();
    m_ready = '1;
    tick();

    // sweep every alarm/replacement combination against every fault pattern
    for (int e = 0; e < 512; e++) begin
      write_cfg({e[8:0], 1'b1 ^ (e % 5 == 0)});
      for (int f = 0; f < 32; f++) begin
        logic [4:0] g;
        g = 5'($urandom);
        gpi_i     = {~g[0], ~f[0]};
        los_i     = {g[1], f[1]};
        nosync_i  = {g[2], f[2]};
        nolock_i  = {g[3], f[3]};
        badcode_i = {g[4], f[4]};
        dec_en    = 1'($urandom);
        s_valid   = 2'($urandom | $urandom);
        m_ready   = 2'($urandom | $urandom);
        s_data    = 32'($urandom);
        s_k       = 4'($urandom);
        tick();
      end
    end
    finish_run();
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule